// File: doc/BRIEF.md
# Downstream Port Power and Overcurrent Manager

This block owns the power switches of a hub's downstream ports. The request decoder hands it single-cycle strobes: turn a port's power on, turn it off, or acknowledge that port's overcurrent change. Each strobe carries a binary port number. The block drives one enable line per external power switch and one connect-indicator line per port. It also keeps two bits per port for the status reporter. The first says the port is in an overcurrent condition. The second says that this condition has changed since the host last acknowledged it.

An overcurrent input passes through a two-flop synchronizer. Once synchronized, it turns the port's power off at once and latches both bits. The port's indicator then blinks with a half-period of half a second. The blinking stops when the host switches that port off or when the hub is reinitialized. Outside an overcurrent, the indicator shows that the port is powered and enabled. Power can only be granted after the host has configured the hub.

Top module: `port_power_mgr`

## Requirements
- R1: A port's power enable rises one cycle after a set-power strobe whose index equals that port, and only if the hub-configured flag is high in that cycle. A set strobe while unconfigured is ignored. Other ports are not touched.
- R2: A clear-power strobe for a port drops that port's power enable one cycle later and leaves every other port as it was.
- R3: An overcurrent input that is held high reaches the port logic after two synchronizer flops. On the third rising edge after it rises, the port's power enable is low and its overcurrent status and change bits are both 1. While the synchronized overcurrent is high, a set-power strobe for that port has no effect.
- R4: Between a port's overcurrent status bit becoming 1 and that port receiving a clear-power strobe or an initialize strobe, the status bit stays 1.
- R5: The change bit stays 1 until a clear-change strobe for that port arrives, and then goes to 0 one cycle later. The clear-change strobe leaves the overcurrent status bit unchanged.
- R6: While a port's overcurrent status bit is 1, its indicator toggles every HALF = CLK_HZ/2 cycles. Any window of 4*HALF consecutive cycles therefore holds exactly 4 transitions.
- R7: A clear-power strobe for a port whose overcurrent input has gone low clears that port's status bit and stops the blinking, so the indicator is low.
- R8: An initialize strobe clears the power, status and change bits of all ports one cycle later. It takes priority over every other input.
- R9: After reset every output is 0. While a port's status bit is 0, its indicator equals its power enable AND its port-enabled input, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hub_cfg_i | input | 1 | Hub configured by the host |
| init_i | input | 1 | Reinitialize strobe (hub reset or re-enumeration) |
| set_pwr_i | input | 1 | Set-port-power strobe |
| clr_pwr_i | input | 1 | Clear-port-power strobe |
| clr_chg_i | input | 1 | Clear-overcurrent-change strobe |
| port_idx_i | input | IDX_W | Binary port number for the strobes |
| ovc_i | input | NUM_PORTS | Asynchronous overcurrent flags, one per port |
| port_en_i | input | NUM_PORTS | Port-enabled status, one per port |
| pwr_en_o | output | NUM_PORTS | Power switch enables |
| stat_o | output | NUM_PORTS | Connect / blink indicators |
| oc_status_o | output | NUM_PORTS | Overcurrent status bits |
| oc_change_o | output | NUM_PORTS | Overcurrent change bits |

## Verification
Directed cases cover four situations. A set strobe while unconfigured shows that the configuration gate is separate from index decoding. A clear on one of several powered ports shows that ports are isolated. An overcurrent held across a set strobe shows that overcurrent takes priority over power-on. A long overcurrent window, in which transitions are counted, separates the correct blink period from an off-by-one prescaler. After that, thousands of cycles of seeded random strobes, indices, enables, overcurrent changes and rare initialize strobes are checked against a bench-side model. This random run exposes priority mistakes between colliding strobes and latency errors in the synchronizer path.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  function automatic int idx_width(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction
endpackage

// File: rtl/ppm_sync.sv
module ppm_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/ppm_blink_timer.sv
module ppm_blink_timer
  import ppm_pkg::*;
#(
  parameter int HALF_CYC = 6_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase_o
);
  localparam int CNT_W = idx_width(HALF_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d;
  logic             wrap;

  always_comb begin
    wrap    = (cnt_q == LAST);
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    phase_d = wrap ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_phase_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q)) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/ppm_port_ctrl.sv
module ppm_port_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic cfg_i,
  input  logic set_hit_i,
  input  logic clr_hit_i,
  input  logic chg_hit_i,
  input  logic ovc_s_i,
  input  logic en_i,
  input  logic phase_i,
  output logic pwr_o,
  output logic stat_o,
  output logic oc_o,
  output logic chg_o
);
  logic pwr_q, pwr_d;
  logic oc_q, oc_d;
  logic chg_q, chg_d;

  always_comb begin
    pwr_d = pwr_q;
    oc_d  = oc_q;
    chg_d = chg_q;
    if (init_i) begin
      pwr_d = 1'b0;
      oc_d  = 1'b0;
      chg_d = 1'b0;
    end else begin
      if (ovc_s_i) begin
        pwr_d = 1'b0;
        oc_d  = 1'b1;
      end else if (clr_hit_i) begin
        pwr_d = 1'b0;
        oc_d  = 1'b0;
      end else if (set_hit_i && cfg_i) begin
        pwr_d = 1'b1;
      end
      if (ovc_s_i)        chg_d = 1'b1;
      else if (chg_hit_i) chg_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= 1'b0;
      oc_q  <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      pwr_q <= pwr_d;
      oc_q  <= oc_d;
      chg_q <= chg_d;
    end
  end

  assign pwr_o  = pwr_q;
  assign oc_o   = oc_q;
  assign chg_o  = chg_q;
  assign stat_o = oc_q ? phase_i : (pwr_q & en_i);

  assert_pwr_needs_cfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_q) |-> $past(set_hit_i && cfg_i && !init_i));
  assert_clr_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit_i |=> !pwr_q);
  assert_ovc_cuts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovc_s_i && !init_i) |=> (oc_q && chg_q && !pwr_q));
  assert_oc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_q && !clr_hit_i && !init_i) |=> oc_q);
  assert_chg_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_hit_i && !ovc_s_i && !clr_hit_i && !init_i) |=> (!chg_q && $stable(oc_q)));
  assert_init_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (!pwr_q && !oc_q && !chg_q));
  assert_stat_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_q && !pwr_q) |-> !stat_o);
endmodule

// File: rtl/port_power_mgr.sv
module port_power_mgr
  import ppm_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CLK_HZ    = 12_000_000,
  localparam int IDX_W    = idx_width(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hub_cfg_i,
  input  logic                 init_i,
  input  logic                 set_pwr_i,
  input  logic                 clr_pwr_i,
  input  logic                 clr_chg_i,
  input  logic [IDX_W-1:0]     port_idx_i,
  input  logic [NUM_PORTS-1:0] ovc_i,
  input  logic [NUM_PORTS-1:0] port_en_i,
  output logic [NUM_PORTS-1:0] pwr_en_o,
  output logic [NUM_PORTS-1:0] stat_o,
  output logic [NUM_PORTS-1:0] oc_status_o,
  output logic [NUM_PORTS-1:0] oc_change_o
);
  localparam int HALF_CYC = (CLK_HZ / 2 > 0) ? CLK_HZ / 2 : 1;

  logic                 rst_meta_q, rst_sync_q;
  logic [NUM_PORTS-1:0] ovc_s;
  logic                 phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ppm_sync #(.W(NUM_PORTS)) u_ovc_sync (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .async_i (ovc_i),
    .sync_o  (ovc_s)
  );

  ppm_blink_timer #(.HALF_CYC(HALF_CYC)) u_blink (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .phase_o (phase)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic sel;
    assign sel = (port_idx_i == IDX_W'(p));

    ppm_port_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_sync_q),
      .init_i    (init_i),
      .cfg_i     (hub_cfg_i),
      .set_hit_i (set_pwr_i & sel),
      .clr_hit_i (clr_pwr_i & sel),
      .chg_hit_i (clr_chg_i & sel),
      .ovc_s_i   (ovc_s[p]),
      .en_i      (port_en_i[p]),
      .phase_i   (phase),
      .pwr_o     (pwr_en_o[p]),
      .stat_o    (stat_o[p]),
      .oc_o      (oc_status_o[p]),
      .chg_o     (oc_change_o[p])
    );
  end
endmodule

// File: tb/port_power_mgr_test.sv
module port_power_mgr_test;
  localparam int N     = 4;
  localparam int HZ    = 20;
  localparam int HALF  = HZ / 2;
  localparam int IW    = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic hub_cfg_i, init_i, set_pwr_i, clr_pwr_i, clr_chg_i;
  logic [IW-1:0] port_idx_i;
  logic [N-1:0]  ovc_i, port_en_i;
  logic [N-1:0]  pwr_en_o, stat_o, oc_status_o, oc_change_o;

  always #2 clk = ~clk;

  port_power_mgr #(.NUM_PORTS(N), .CLK_HZ(HZ)) uut (
    .clk(clk), .rst_n(rst_n), .hub_cfg_i(hub_cfg_i), .init_i(init_i),
    .set_pwr_i(set_pwr_i), .clr_pwr_i(clr_pwr_i), .clr_chg_i(clr_chg_i),
    .port_idx_i(port_idx_i), .ovc_i(ovc_i), .port_en_i(port_en_i),
    .pwr_en_o(pwr_en_o), .stat_o(stat_o), .oc_status_o(oc_status_o),
    .oc_change_o(oc_change_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [N-1:0] m_pwr, m_oc, m_chg, m_s1, m_s2;

  function automatic logic [2:0] port_next(input logic [2:0] cur, input logic init,
      input logic ovc, input logic clr, input logic set, input logic cfg, input logic cc);
    logic p, o, c;
    {p, o, c} = cur;
    if (init) return 3'b000;
    if (ovc) begin p = 0; o = 1; c = 1; end
    else begin
      if (clr) begin p = 0; o = 0; end
      else if (set && cfg) p = 1;
      if (cc) c = 0;
    end
    return {p, o, c};
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    for (int p = 0; p < N; p++) begin
      logic [2:0] nx;
      logic hit;
      hit = (port_idx_i == IW'(p));
      nx = port_next({m_pwr[p], m_oc[p], m_chg[p]}, init_i, m_s2[p],
                     clr_pwr_i & hit, set_pwr_i & hit, hub_cfg_i, clr_chg_i & hit);
      {m_pwr[p], m_oc[p], m_chg[p]} = nx;
    end
    m_s2 = m_s1;
    m_s1 = ovc_i;
    @(negedge clk);
  endtask

  task automatic strobe(input int kind, input int idx);
    port_idx_i = IW'(idx);
    set_pwr_i = (kind == 1);
    clr_pwr_i = (kind == 2);
    clr_chg_i = (kind == 3);
    init_i    = (kind == 4);
    step();
    {set_pwr_i, clr_pwr_i, clr_chg_i, init_i} = '0;
  endtask

  function automatic logic [N-1:0] exp_stat(input logic [N-1:0] mask);
    return (m_pwr & port_en_i) & mask;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    int trans;
    logic prev;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 0; hub_cfg_i = 0; init_i = 0; set_pwr_i = 0; clr_pwr_i = 0;
    clr_chg_i = 0; port_idx_i = 0; ovc_i = 0; port_en_i = 4'b1111;
    m_pwr = 0; m_oc = 0; m_chg = 0; m_s1 = 0; m_s2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) step();
    // R9 reset state
    check("R9 reset pwr", pwr_en_o, 4'b0);
    check("R9 reset stat", stat_o, 4'b0);
    check("R9 reset oc", oc_status_o | oc_change_o, 4'b0);

    // R1 unconfigured set ignored
    strobe(1, 2);
    check("R1 set unconfigured", pwr_en_o, 4'b0000);
    hub_cfg_i = 1;
    strobe(1, 2);
    check("R1 set port2", pwr_en_o, 4'b0100);
    check("R9 stat follows pwr", stat_o, 4'b0100);
    port_en_i = 4'b1011;
    #1 check("R9 stat gated by enable", stat_o, 4'b0000);
    port_en_i = 4'b1111;

    // R2 clear one port only
    strobe(1, 0); strobe(1, 1); strobe(1, 3);
    check("R1 set all", pwr_en_o, 4'b1111);
    strobe(2, 2);
    check("R2 clear port2 only", pwr_en_o, 4'b1011);

    // R3 overcurrent on port1, latency
    ovc_i = 4'b0010;
    step(); step();
    check("R3 before sync done", pwr_en_o, 4'b1011);
    step();
    check("R3 pwr cut", pwr_en_o, 4'b1001);
    check("R3 status", oc_status_o, 4'b0010);
    check("R3 change", oc_change_o, 4'b0010);
    strobe(1, 1);
    check("R3 set during ovc ignored", pwr_en_o, 4'b1001);

    // R6 blink period
    trans = 0;
    prev = stat_o[1];
    for (int c = 0; c < 4 * HALF; c++) begin
      step();
      if (stat_o[1] != prev) trans++;
      prev = stat_o[1];
    end
    check("R6 blink transitions", 4'(trans), 4'd4);

    // R5 change clear keeps status
    ovc_i = 0;
    step(); step(); step();
    strobe(3, 1);
    check("R5 change cleared", oc_change_o, 4'b0000);
    check("R5 status kept", oc_status_o, 4'b0010);
    check("R4 status held", oc_status_o, 4'b0010);

    // R7 clear power ends blink
    strobe(2, 1);
    check("R7 status cleared", oc_status_o, 4'b0000);
    trans = 0;
    for (int c = 0; c < 3 * HALF; c++) begin
      step();
      if (stat_o[1]) trans++;
    end
    check("R7 indicator dark", 4'(trans), 4'd0);

    // R8 init clears all
    ovc_i = 4'b1000;
    repeat (3) step();
    ovc_i = 0;
    repeat (2) step();
    strobe(4, 0);
    check("R8 init pwr", pwr_en_o, 4'b0);
    check("R8 init flags", oc_status_o | oc_change_o, 4'b0);

    // random run against model
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      if ($urandom_range(0, 39) == 0) ovc_i[$urandom_range(0, N-1)] ^= 1'b1;
      if ($urandom_range(0, 19) == 0) port_en_i = 4'($urandom);
      if ($urandom_range(0, 99) == 0) hub_cfg_i = ~hub_cfg_i;
      port_idx_i = IW'($urandom_range(0, N-1));
      set_pwr_i = (r < 30);
      clr_pwr_i = (r >= 30 && r < 45) || (r == 99 && c[0]);
      clr_chg_i = (r >= 45 && r < 60) || (r == 99);
      init_i    = (r == 98);
      step();
      {set_pwr_i, clr_pwr_i, clr_chg_i, init_i} = '0;
      check("R1/R2/R3 random pwr", pwr_en_o, m_pwr);
      check("R4/R7 random status", oc_status_o, m_oc);
      check("R5/R8 random change", oc_change_o, m_chg);
      check("R9 random stat", stat_o & ~m_oc, exp_stat(~m_oc));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule